// File: doc/BRIEF.md
# Dual Exponent Adjust and Exception Stage for a Fused Add-Subtract Unit

This block is the back end of a dual-path fused floating-point add-subtract unit. The front end computes the sum and the difference of two operands at the same time, each on a far path and on a close path. This block receives the larger biased exponent, the path choice and the per-path correction terms. It picks the far or the close fraction for each operation and adjusts two exponents in parallel. Each adjustment uses its own correction source. The sum takes a one-bit increment from its significand overflow. The difference takes a one-bit decrement on the far path and a leading-zero count on the close path. The far-path rounding carries also enter both adjustments.

Exceptions use abrupt handling. Overflow is only possible on the sum, and it turns the sum into a signed infinity. Underflow is only possible on the difference, and it flushes the difference to a signed zero. Inexact is raised when the far path discarded nonzero bits or when either exception fires. Both packed results and their flag triples are registered, so they appear one clock after a valid input.

Top module: `dual_exp_adjust`

## Requirements
- R1: With `path_far`=1 both results carry the far-path fractions (`far_sum_frac`, `far_dif_frac`). With `path_far`=0 they carry the close-path fractions. This holds whenever the result is not forced to infinity or zero.
- R2: The sum exponent is `big_exp` plus the selected increment (`far_sum_inc` on the far path, `close_sum_inc` on the close path) plus `sum_round_carry` on the far path.
- R3: If the sum exponent is 255 or more (all ones for `EXP_W`=8), the sum word becomes {sign, all-ones exponent, zero fraction}. Its flags then read 3'b110.
- R4: The difference exponent is `big_exp - far_dif_dec + dif_round_carry` on the far path and `big_exp - close_norm_shift` on the close path.
- R5: If the difference exponent is 0 or less, the difference word becomes {sign, zero exponent, zero fraction}. Its flags then read 3'b101.
- R6: The overflow flag (bit 1) of `dif_flags` and the underflow flag (bit 0) of `sum_flags` are always 0.
- R7: On the far path, inexact (bit 2) follows `sum_lost_bits` / `dif_lost_bits`. On the close path, the lost-bit and round-carry inputs have no effect. Inexact is then set only by an exception.
- R8: On the close path with `close_dif_zero`=1, the difference is an exact signed zero {sign, 0, 0} with flags 3'b000. On the far path this input is ignored.
- R9: Results are registered. `out_valid` equals `in_valid` one clock later. The words and flags hold their values while `in_valid` is 0.
- R10: While `rst_n` is 0, `out_valid`, both words and both flag triples are 0.
- Word layout: bit [WORD_W-1] is the sign, the next `EXP_W` bits are the biased exponent, and the low `MAN_W` bits are the fraction.
- Flag layout: bit 2 is inexact, bit 1 is overflow, bit 0 is underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inputs carry an operation this cycle |
| big_exp | input | EXP_W | Larger biased exponent of the operands |
| path_far | input | 1 | 1 selects the far path, 0 the close path |
| sum_sign | input | 1 | Sign of the sum from the sign logic |
| dif_sign | input | 1 | Sign of the difference from the sign logic |
| far_sum_frac | input | MAN_W | Normalized far-path sum fraction |
| close_sum_frac | input | MAN_W | Normalized close-path sum fraction |
| far_dif_frac | input | MAN_W | Normalized far-path difference fraction |
| close_dif_frac | input | MAN_W | Normalized close-path difference fraction |
| far_sum_inc | input | 1 | Far-path significand addition overflow |
| close_sum_inc | input | 1 | Close-path significand addition overflow |
| far_dif_dec | input | 1 | Far-path subtraction underflow (1-bit left shift) |
| close_norm_shift | input | SHIFT_W | Close-path leading-zero normalization count |
| close_dif_zero | input | 1 | Close-path subtraction cancelled exactly |
| sum_round_carry | input | 1 | Far-path rounding carried into the sum exponent |
| dif_round_carry | input | 1 | Far-path rounding carried into the difference exponent (only with far_dif_dec) |
| sum_lost_bits | input | 1 | Far path discarded nonzero bits for the sum |
| dif_lost_bits | input | 1 | Far path discarded nonzero bits for the difference |
| out_valid | output | 1 | Registered results are valid |
| sum_word | output | WORD_W | Packed sum result |
| dif_word | output | WORD_W | Packed difference result |
| sum_flags | output | 3 | Sum flags {inexact, overflow, underflow} |
| dif_flags | output | 3 | Difference flags {inexact, overflow, underflow} |

## Verification
The bench builds the block with its default parameters: `EXP_W`=8, `MAN_W`=23 and the derived 5-bit shift count. With these values the exponent boundaries sit at 0 and 255. Increments from 253 and 254, and shift counts equal to, just below and above the larger exponent, can therefore reach both exception edges exactly. A behavioural model predicts every output from integers and is compared on each clock. Directed vectors hit the boundaries, the ignored inputs and the hold behaviour, and a long run of random valid and idle cycles follows.

// File: rtl/dexp_pkg.sv
// Shared types for the dual exponent adjust stage.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package dexp_pkg;

    // Path selection between the two front-end data paths.
    typedef enum logic {
        PATH_CLOSE = 1'b0,
        PATH_FAR   = 1'b1
    } path_e;

    // Per-result exception flags; bit order is part of the port contract.
    typedef struct packed {
        logic inexact;
        logic overflow;
        logic underflow;
    } exc_flags_t;

    localparam int FLAG_W = $bits(exc_flags_t);

endpackage

// File: rtl/dexp_path_mux.sv
// Two-way selector between a far-path and a close-path value.
// Assumes the select is stable for the whole cycle; purely combinational.
module dexp_path_mux #(
    parameter int W = 23
) (
    input  logic                 sel_far,
    input  logic [W-1:0]         far_val,
    input  logic [W-1:0]         close_val,
    output logic [W-1:0]         out_val
);
    import dexp_pkg::*;

    path_e sel_path;

    // Decode the select into the path type and steer the chosen value.
    always_comb begin
        sel_path = path_e'(sel_far);
        out_val  = (sel_path == PATH_FAR) ? far_val : close_val;
    end

endmodule

// File: rtl/dexp_sum_adjust.sv
// Exponent adjust and overflow check for the addition result.
// Adds the path-selected overflow increment and, on the far path only, the
// rounding carry to the larger exponent. An exponent at or past the all-ones
// code turns the result into a signed infinity. Assumes big_exp is a finite
// normal exponent; the sum can never underflow.
module dexp_sum_adjust #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                  path_far,
    input  logic [EXP_W-1:0]      big_exp,
    input  logic                  far_inc,
    input  logic                  close_inc,
    input  logic                  rnd_carry,
    input  logic                  lost_bits,
    input  logic [MAN_W-1:0]      frac_sel,
    output logic [EXP_W-1:0]      exp_out,
    output logic [MAN_W-1:0]      frac_out,
    output dexp_pkg::exc_flags_t  flags
);
    import dexp_pkg::*;

    localparam int CALC_W = EXP_W + 2;
    localparam logic [CALC_W-1:0] EXP_INF = {2'b00, {EXP_W{1'b1}}};

    logic              inc_bit;
    logic              carry_bit;
    logic [CALC_W-1:0] exp_ext;
    logic              ovf;

    // Form the widened exponent from the path-specific correction terms.
    always_comb begin
        inc_bit   = path_far ? far_inc : close_inc;
        carry_bit = path_far & rnd_carry;
        exp_ext   = {2'b00, big_exp} + CALC_W'(inc_bit) + CALC_W'(carry_bit);
        ovf       = (exp_ext >= EXP_INF);
    end

    // Saturate to infinity on overflow and raise the matching flags.
    always_comb begin
        if (ovf) begin
            exp_out  = {EXP_W{1'b1}};
            frac_out = '0;
        end else begin
            exp_out  = exp_ext[EXP_W-1:0];
            frac_out = frac_sel;
        end
        flags.overflow  = ovf;
        flags.underflow = 1'b0;
        flags.inexact   = ovf | (path_far & lost_bits);
    end

endmodule

// File: rtl/dexp_dif_adjust.sv
// Exponent adjust and abrupt-underflow check for the subtraction result.
// Far path: subtract the one-bit normalization decrement and add back the
// rounding carry. Close path: subtract the leading-zero count; rounding never
// applies there. An exact close-path cancellation yields an exact zero.
// Assumes rnd_carry is only raised together with far_dec, so the difference
// exponent never exceeds big_exp and overflow cannot occur.
module dexp_dif_adjust #(
    parameter int EXP_W   = 8,
    parameter int MAN_W   = 23,
    parameter int SHIFT_W = 5
) (
    input  logic                  path_far,
    input  logic [EXP_W-1:0]      big_exp,
    input  logic                  far_dec,
    input  logic                  rnd_carry,
    input  logic [SHIFT_W-1:0]    close_shift,
    input  logic                  close_zero,
    input  logic                  lost_bits,
    input  logic [MAN_W-1:0]      frac_sel,
    output logic [EXP_W-1:0]      exp_out,
    output logic [MAN_W-1:0]      frac_out,
    output dexp_pkg::exc_flags_t  flags
);
    import dexp_pkg::*;

    localparam int CALC_W = EXP_W + 2;

    logic [CALC_W-1:0] base_ext;
    logic [CALC_W-1:0] exp_ext;
    logic              exact_zero;
    logic              unf;

    // Form the widened exponent; bit CALC_W-1 acts as the sign of the result.
    always_comb begin
        base_ext = {2'b00, big_exp};
        if (path_far)
            exp_ext = base_ext - CALC_W'(far_dec) + CALC_W'(rnd_carry & far_dec);
        else
            exp_ext = base_ext - CALC_W'(close_shift);
        exact_zero = ~path_far & close_zero;
        unf        = ~exact_zero & (exp_ext[CALC_W-1] | (exp_ext == '0));
    end

    // Flush to zero on underflow or exact cancellation and set the flags.
    always_comb begin
        if (unf | exact_zero) begin
            exp_out  = '0;
            frac_out = '0;
        end else begin
            exp_out  = exp_ext[EXP_W-1:0];
            frac_out = frac_sel;
        end
        flags.overflow  = 1'b0;
        flags.underflow = unf;
        flags.inexact   = unf | (path_far & ~exact_zero & lost_bits);
    end

endmodule

// File: rtl/dual_exp_adjust.sv
// Back end of a dual-path fused add-subtract unit.
// Selects far or close fractions for both operations, adjusts the sum and
// difference exponents in parallel, applies abrupt overflow/underflow handling
// and registers both packed results with their flags.
// Assumes normal operands (big_exp between 1 and all-ones minus one) and
// SHIFT_W no wider than EXP_W+1.
module dual_exp_adjust #(
    parameter int EXP_W   = 8,
    parameter int MAN_W   = 23,
    parameter int SHIFT_W = $clog2(MAN_W + 2),
    parameter int WORD_W  = 1 + EXP_W + MAN_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [EXP_W-1:0]    big_exp,
    input  logic                path_far,
    input  logic                sum_sign,
    input  logic                dif_sign,
    input  logic [MAN_W-1:0]    far_sum_frac,
    input  logic [MAN_W-1:0]    close_sum_frac,
    input  logic [MAN_W-1:0]    far_dif_frac,
    input  logic [MAN_W-1:0]    close_dif_frac,
    input  logic                far_sum_inc,
    input  logic                close_sum_inc,
    input  logic                far_dif_dec,
    input  logic [SHIFT_W-1:0]  close_norm_shift,
    input  logic                close_dif_zero,
    input  logic                sum_round_carry,
    input  logic                dif_round_carry,
    input  logic                sum_lost_bits,
    input  logic                dif_lost_bits,
    output logic                out_valid,
    output logic [WORD_W-1:0]   sum_word,
    output logic [WORD_W-1:0]   dif_word,
    output logic [2:0]          sum_flags,
    output logic [2:0]          dif_flags
);
    import dexp_pkg::*;

    localparam int N_OPS = 2;
    localparam int OP_SUM = 0;
    localparam int OP_DIF = 1;

    logic [MAN_W-1:0] far_frac   [N_OPS];
    logic [MAN_W-1:0] close_frac [N_OPS];
    logic [MAN_W-1:0] sel_frac   [N_OPS];

    logic [EXP_W-1:0] sum_exp_c, dif_exp_c;
    logic [MAN_W-1:0] sum_frac_c, dif_frac_c;
    exc_flags_t       sum_flags_c, dif_flags_c;

    // Gather the per-operation fraction candidates for the selectors.
    always_comb begin
        far_frac[OP_SUM]   = far_sum_frac;
        far_frac[OP_DIF]   = far_dif_frac;
        close_frac[OP_SUM] = close_sum_frac;
        close_frac[OP_DIF] = close_dif_frac;
    end

    // One path selector per operation, both driven by the same path decision.
    for (genvar op = 0; op < N_OPS; op++) begin : g_sel
        dexp_path_mux #(.W(MAN_W)) u_mux (
            .sel_far   (path_far),
            .far_val   (far_frac[op]),
            .close_val (close_frac[op]),
            .out_val   (sel_frac[op])
        );
    end

    dexp_sum_adjust #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sum (
        .path_far  (path_far),
        .big_exp   (big_exp),
        .far_inc   (far_sum_inc),
        .close_inc (close_sum_inc),
        .rnd_carry (sum_round_carry),
        .lost_bits (sum_lost_bits),
        .frac_sel  (sel_frac[OP_SUM]),
        .exp_out   (sum_exp_c),
        .frac_out  (sum_frac_c),
        .flags     (sum_flags_c)
    );

    dexp_dif_adjust #(.EXP_W(EXP_W), .MAN_W(MAN_W), .SHIFT_W(SHIFT_W)) u_dif (
        .path_far    (path_far),
        .big_exp     (big_exp),
        .far_dec     (far_dif_dec),
        .rnd_carry   (dif_round_carry),
        .close_shift (close_norm_shift),
        .close_zero  (close_dif_zero),
        .lost_bits   (dif_lost_bits),
        .frac_sel    (sel_frac[OP_DIF]),
        .exp_out     (dif_exp_c),
        .frac_out    (dif_frac_c),
        .flags       (dif_flags_c)
    );

    // Result register: capture on valid input, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            sum_word  <= '0;
            dif_word  <= '0;
            sum_flags <= '0;
            dif_flags <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sum_word  <= {sum_sign, sum_exp_c, sum_frac_c};
                dif_word  <= {dif_sign, dif_exp_c, dif_frac_c};
                sum_flags <= sum_flags_c;
                dif_flags <= dif_flags_c;
            end
        end
    end

endmodule

// File: rtl/dual_exp_adjust_chk.sv
// Property checker for dual_exp_adjust, attached by bind below.
// Observes ports only; assumes the same parameters as the bound instance.
module dual_exp_adjust_chk #(
    parameter int EXP_W  = 8,
    parameter int MAN_W  = 23,
    parameter int WORD_W = 1 + EXP_W + MAN_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              path_far,
    input logic              close_dif_zero,
    input logic              out_valid,
    input logic [WORD_W-1:0] sum_word,
    input logic [WORD_W-1:0] dif_word,
    input logic [2:0]        sum_flags,
    input logic [2:0]        dif_flags
);

    // R9: output valid tracks input valid one clock later.
    p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9: results hold while no operation is presented.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sum_word) && $stable(dif_word)
                       && $stable(sum_flags) && $stable(dif_flags)));

    // R6: no overflow on the difference, no underflow on the sum.
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dif_flags[1]);
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sum_flags[0]);

    // R3: an overflowed sum is an infinity and is inexact.
    p_ovf_inf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sum_flags[1] |-> (sum_word[WORD_W-2:MAN_W] == {EXP_W{1'b1}}
                          && sum_word[MAN_W-1:0] == '0 && sum_flags[2]));

    // R5: an underflowed difference is flushed to zero and is inexact.
    p_unf_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dif_flags[0] |-> (dif_word[WORD_W-2:0] == '0 && dif_flags[2]));

    // R7: on the close path the sum is inexact only through overflow.
    p_close_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !path_far) |=> (sum_flags[2] == sum_flags[1]));

    // R8: exact close-path cancellation gives a flag-free zero.
    p_exact_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !path_far && close_dif_zero) |=>
            (dif_flags == 3'b000 && dif_word[WORD_W-2:0] == '0));

endmodule

bind dual_exp_adjust dual_exp_adjust_chk #(
    .EXP_W  (EXP_W),
    .MAN_W  (MAN_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .path_far       (path_far),
    .close_dif_zero (close_dif_zero),
    .out_valid      (out_valid),
    .sum_word       (sum_word),
    .dif_word       (dif_word),
    .sum_flags      (sum_flags),
    .dif_flags      (dif_flags)
);

// File: tb/sim_dual_exp_adjust.sv
`timescale 1ns/1ps
module sim_dual_exp_adjust;
    localparam int EXP_W   = 8;
    localparam int MAN_W   = 23;
    localparam int SHIFT_W = $clog2(MAN_W + 2);
    localparam int WORD_W  = 1 + EXP_W + MAN_W;
    localparam int EXP_ALL = (1 << EXP_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [EXP_W-1:0] big_exp = '0;
    logic path_far = 1'b0, sum_sign = 1'b0, dif_sign = 1'b0;
    logic [MAN_W-1:0] far_sum_frac = '0, close_sum_frac = '0;
    logic [MAN_W-1:0] far_dif_frac = '0, close_dif_frac = '0;
    logic far_sum_inc = 1'b0, close_sum_inc = 1'b0, far_dif_dec = 1'b0;
    logic [SHIFT_W-1:0] close_norm_shift = '0;
    logic close_dif_zero = 1'b0, sum_round_carry = 1'b0, dif_round_carry = 1'b0;
    logic sum_lost_bits = 1'b0, dif_lost_bits = 1'b0;
    logic out_valid;
    logic [WORD_W-1:0] sum_word, dif_word;
    logic [2:0] sum_flags, dif_flags;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Expected register state from the behavioural model.
    logic e_valid = 1'b0;
    logic [WORD_W-1:0] e_sum = '0, e_dif = '0;
    logic [2:0] e_sf = '0, e_df = '0;
    string e_tag = "R10";

    always #10 clk = ~clk;

    dual_exp_adjust u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .big_exp(big_exp),
        .path_far(path_far), .sum_sign(sum_sign), .dif_sign(dif_sign),
        .far_sum_frac(far_sum_frac), .close_sum_frac(close_sum_frac),
        .far_dif_frac(far_dif_frac), .close_dif_frac(close_dif_frac),
        .far_sum_inc(far_sum_inc), .close_sum_inc(close_sum_inc),
        .far_dif_dec(far_dif_dec), .close_norm_shift(close_norm_shift),
        .close_dif_zero(close_dif_zero), .sum_round_carry(sum_round_carry),
        .dif_round_carry(dif_round_carry), .sum_lost_bits(sum_lost_bits),
        .dif_lost_bits(dif_lost_bits), .out_valid(out_valid),
        .sum_word(sum_word), .dif_word(dif_word),
        .sum_flags(sum_flags), .dif_flags(dif_flags)
    );

    task automatic cmp(input string what, input logic [63:0] act, input logic [63:0] exv);
        checks++;
        if (act !== exv) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", e_tag, what, act, exv);
        end
    endtask

    task automatic check_all();
        cmp("out_valid", 64'(out_valid), 64'(e_valid));
        cmp("sum_word",  64'(sum_word),  64'(e_sum));
        cmp("dif_word",  64'(dif_word),  64'(e_dif));
        cmp("sum_flags", 64'(sum_flags), 64'(e_sf));
        cmp("dif_flags", 64'(dif_flags), 64'(e_df));
    endtask

    // Check the previous cycle's result, then drive one vector and predict it.
    task automatic vec(input bit v, input int big, input bit far, input bit fao,
                       input bit cao, input bit dec, input int lz, input bit cz,
                       input bit arc, input bit drc, input bit al, input bit dl,
                       input string tag);
        logic [MAN_W-1:0] fs, cs, fd, cd;
        bit ss, ds;
        int es, ed;
        @(negedge clk);
        check_all();
        fs = MAN_W'($urandom); cs = MAN_W'($urandom);
        fd = MAN_W'($urandom); cd = MAN_W'($urandom);
        ss = 1'($urandom); ds = 1'($urandom);
        in_valid = v; big_exp = EXP_W'(big); path_far = far;
        sum_sign = ss; dif_sign = ds;
        far_sum_frac = fs; close_sum_frac = cs; far_dif_frac = fd; close_dif_frac = cd;
        far_sum_inc = fao; close_sum_inc = cao; far_dif_dec = dec;
        close_norm_shift = SHIFT_W'(lz); close_dif_zero = cz;
        sum_round_carry = arc; dif_round_carry = drc;
        sum_lost_bits = al; dif_lost_bits = dl;
        e_tag = tag;
        e_valid = v;
        if (v) begin
            es = big + (far ? int'(fao) : int'(cao)) + ((far && arc) ? 1 : 0);
            if (es >= EXP_ALL) begin
                e_sum = {ss, EXP_W'(EXP_ALL), MAN_W'(0)};
                e_sf = 3'b110;
            end else begin
                e_sum = {ss, EXP_W'(es), (far ? fs : cs)};
                e_sf = {(far && al), 2'b00};
            end
            ed = far ? (big - int'(dec) + ((drc && dec) ? 1 : 0)) : (big - lz);
            if (!far && cz) begin
                e_dif = {ds, {(WORD_W-1){1'b0}}};
                e_df = 3'b000;
            end else if (ed <= 0) begin
                e_dif = {ds, {(WORD_W-1){1'b0}}};
                e_df = 3'b101;
            end else begin
                e_dif = {ds, EXP_W'(ed), (far ? fd : cd)};
                e_df = {(far && dl), 2'b00};
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check_all();
        rst_n = 1'b1;
        //   v  big far fao cao dec lz cz arc drc al dl
        vec(1, 100, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 far fractions");
        vec(1, 100, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R1 close fractions");
        vec(1, 100, 1, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R2 far inc+carry");
        vec(1, 100, 0, 0, 1, 0, 2, 0, 1, 0, 0, 0, "R2 close inc, carry ignored");
        vec(1, 100, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R2 close inc unused on far");
        vec(1, 254, 1, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R3 overflow from 254");
        vec(1, 253, 1, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R3 overflow via carry");
        vec(1, 253, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R3 largest finite");
        vec(1, 254, 0, 0, 1, 0, 3, 0, 0, 0, 0, 0, "R3 close overflow");
        vec(1, 50, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R4 far decrement");
        vec(1, 50, 1, 0, 0, 1, 0, 0, 0, 1, 0, 0, "R4 far dec with carry");
        vec(1, 50, 0, 0, 0, 0, 23, 0, 0, 0, 0, 0, "R4 close shift");
        vec(1, 3, 0, 0, 0, 0, 3, 0, 0, 0, 0, 0, "R5 shift equals exponent");
        vec(1, 4, 0, 0, 0, 0, 3, 0, 0, 0, 0, 0, "R5 smallest normal");
        vec(1, 2, 0, 0, 0, 0, 31, 0, 0, 0, 0, 0, "R5 deep underflow");
        vec(1, 1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R5 far underflow");
        vec(1, 254, 1, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R6 no dif overflow");
        vec(1, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R6 no sum underflow");
        vec(1, 80, 1, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R7 far lost bits");
        vec(1, 80, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R7 far sum lost only");
        vec(1, 80, 0, 0, 0, 0, 1, 0, 1, 1, 1, 1, "R7 close ignores lost/carry");
        vec(1, 2, 0, 0, 0, 0, 31, 1, 0, 0, 0, 0, "R8 exact zero");
        vec(1, 60, 1, 0, 0, 1, 0, 1, 0, 0, 0, 0, "R8 ignored on far");
        vec(0, 200, 1, 1, 1, 1, 9, 1, 1, 1, 1, 1, "R9 idle hold");
        vec(0, 7, 0, 0, 0, 0, 7, 0, 0, 0, 0, 0, "R9 idle hold again");
        vec(1, 120, 0, 1, 0, 0, 4, 0, 0, 0, 0, 0, "R9 resume");
        for (int i = 0; i < 600; i++) begin
            bit d;
            d = 1'($urandom);
            vec(($urandom_range(7) != 0), 1 + int'($urandom_range(253)),
                1'($urandom), 1'($urandom), 1'($urandom), d,
                int'($urandom_range(31)), ($urandom_range(5) == 0),
                1'($urandom), d & 1'($urandom), 1'($urandom), 1'($urandom),
                "R2 R4 random");
        end
        @(negedge clk);
        check_all();
        finish_run();
    end
endmodule